// File: doc/BRIEF.md
# Serial three-wire EEPROM command front end

This block is the slave side of a small serial-access EEPROM. Chip select, serial clock and serial data-in arrive asynchronously. They are resynchronised into the system clock domain, and all serial decoding runs on the detected edges of the serial clock. After a select with the serial clock low, the first 1 sampled on data-in is the start bit. Two opcode bits follow, then an address field whose width depends on the organization input: one bit longer when the array is read as bytes.

Read commands are served directly from an internal register array. The block emits one zero bit, then the addressed byte or word with the most significant bit first. It keeps streaming the following locations for as long as chip select stays high, and the address wraps to zero past the top. Every other command is turned into a one-cycle command strobe that carries the operation, the address and the data toward the program-cycle controller. The strobe fires only if chip select falls with no serial clock edge after the last expected bit. The same strobe also updates the internal array at once, so data that has been written can be read back through the serial port.

Top module: `uw_front`

## Requirements
- R1: Out of reset, q_oe_o and q_o are 0, no command strobe is issued, and every array location reads as all ones (FFFFh as a word, FFh as a byte).
- R2: A command starts only after chip select rises while the serial clock is low. Zeros sampled before the first 1 are ignored. If chip select rises while the serial clock is high, nothing is decoded until chip select has been low again.
- R3: The two opcode bits after the start bit select the command: 10 read, 01 write, 11 erase one location, 00 extended. cmd_op_o codes are 1 write, 2 erase, 3 enable, 4 disable, 5 erase-all, 6 write-all.
- R4: After the last address bit of a read, q_oe_o is 1 and q_o is 0 for one serial clock. Data bits then follow MSB first, each updated on a rising serial clock edge. q_oe_o is 0 whenever chip select is low.
- R5: While chip select stays high, a read moves on to the next location with no further zero bit, and wraps from the highest address to address 0.
- R6: org_i=1 selects 16-bit words with a 6-bit address. org_i=0 selects bytes with a 7-bit address, where address bit 0 = 0 is the low byte of word addr>>1 and 1 is its high byte.
- R7: A write (opcode 01) takes 16 or 8 data bits, MSB first. When chip select falls, cmd_valid_o pulses for one cycle with op, organization, address and data, and the addressed location takes the data.
- R8: Erase (11) sets the addressed location to all ones. Erase-all sets the whole array to ones. Write-all fills every word with the data; in byte mode the byte goes into both halves.
- R9: If a serial clock rising edge arrives after the final bit of a non-read command and before chip select falls, no strobe is issued and the array is unchanged.
- R10: If chip select drops before a command is complete, the partial command is discarded with no strobe and no array change.
- R11: In the extended group, the top two address bits select the command: 11 enable, 00 disable, 10 erase-all, 01 write-all. The rest of the address is ignored. Enable and disable strobe codes 3 and 4 and leave the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, asynchronous |
| sck_i | input | 1 | Serial clock, asynchronous, several times slower than clk_i |
| din_i | input | 1 | Serial data in |
| org_i | input | 1 | 1 = 16-bit words, 0 = bytes; sampled at the start bit |
| q_o | output | 1 | Serial data out |
| q_oe_o | output | 1 | Output enable for q_o |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 3 | Command code (R3) |
| cmd_wide_o | output | 1 | Organization of the strobed command |
| cmd_addr_o | output | 7 | Address of the strobed command |
| cmd_data_o | output | 16 | Data of the strobed command (byte in low bits) |

## Verification
The hardest conditions to reach are the ones where the serial clock count is off by one. One case is a single extra serial clock pulse between the last data bit and the fall of chip select. The other is chip select dropping partway through the data field. Both must leave the array untouched. The bench drives both cases with its bit-level tasks, then reads the targeted location back over the serial port and counts strobes. Address wrap is reached by starting streamed reads at the top word and the top byte. The expected values there depend on earlier byte writes, so those reads also check that the two organizations map onto the same words.

// File: rtl/uw_pkg.sv
package uw_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_EWEN  = 3'd3,
    OP_EWDS  = 3'd4,
    OP_ERAL  = 3'd5,
    OP_WRAL  = 3'd6
  } uw_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_ARM, S_OPC, S_ADR, S_DAT, S_RD, S_FIN, S_BAD
  } uw_st_e;
endpackage

// File: rtl/uw_sync.sv
module uw_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/uw_array.sv
module uw_array import uw_pkg::*; #(
  parameter int MEM_WORDS = 64,
  localparam int WAW = $clog2(MEM_WORDS),
  localparam int BAW = WAW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  uw_op_e         op_i,
  input  logic           wide_i,
  input  logic [BAW-1:0] addr_i,
  input  logic [15:0]    data_i,
  input  logic [WAW-1:0] rd_waddr_i,
  output logic [15:0]    rd_word_o
);
  logic [15:0] mem_q [MEM_WORDS];
  logic [WAW-1:0] wa;
  logic [15:0] lane, fill, wval;

  always_comb begin
    wa   = wide_i ? addr_i[WAW-1:0] : addr_i[BAW-1:1];
    lane = wide_i ? 16'hFFFF : (addr_i[0] ? 16'hFF00 : 16'h00FF);
    fill = wide_i ? data_i : {data_i[7:0], data_i[7:0]};
    wval = (op_i == OP_ERASE) ? 16'hFFFF : fill;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_WORDS; i++) mem_q[i] <= 16'hFFFF;
    end else if (we_i) begin
      unique case (op_i)
        OP_WRITE, OP_ERASE: mem_q[wa] <= (mem_q[wa] & ~lane) | (wval & lane);
        OP_ERAL: for (int i = 0; i < MEM_WORDS; i++) mem_q[i] <= 16'hFFFF;
        OP_WRAL: for (int i = 0; i < MEM_WORDS; i++) mem_q[i] <= fill;
        default: ;
      endcase
    end
  end

  assign rd_word_o = mem_q[rd_waddr_i];
endmodule

// File: rtl/uw_decoder.sv
module uw_decoder import uw_pkg::*; #(
  parameter int MEM_WORDS = 64,
  localparam int WAW = $clog2(MEM_WORDS),
  localparam int BAW = WAW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_s_i,
  input  logic           sck_s_i,
  input  logic           din_s_i,
  input  logic           org_i,
  input  logic [15:0]    rd_word_i,
  output logic [WAW-1:0] rd_waddr_o,
  output logic           q_o,
  output logic           q_oe_o,
  output logic           cmd_valid_o,
  output uw_op_e         cmd_op_o,
  output logic           cmd_wide_o,
  output logic [BAW-1:0] cmd_addr_o,
  output logic [15:0]    cmd_data_o
);
  localparam logic [BAW-1:0] WMASK = {1'b0, {WAW{1'b1}}};
  localparam logic [BAW-1:0] BMASK = {BAW{1'b1}};

  uw_st_e         state;
  uw_op_e         pend;
  logic           cs_d, sck_d, org_q, q_r;
  logic [1:0]     opc;
  logic [BAW-1:0] adr, rd_adr;
  logic [15:0]    dat;
  logic [4:0]     cnt;
  logic [3:0]     rd_cnt;

  logic           sck_rise, cs_rise, rd_bit;
  logic [BAW-1:0] adr_nxt, amask, rd_inc;
  logic [1:0]     ext;
  logic [4:0]     adr_last, dat_last;
  logic [15:0]    rd_val;
  logic [3:0]     rd_idx;

  always_comb begin
    sck_rise   = sck_s_i & ~sck_d;
    cs_rise    = cs_s_i & ~cs_d;
    adr_nxt    = {adr[BAW-2:0], din_s_i};
    amask      = org_q ? WMASK : BMASK;
    ext        = org_q ? adr_nxt[WAW-1 -: 2] : adr_nxt[BAW-1 -: 2];
    adr_last   = org_q ? 5'(WAW - 1) : 5'(BAW - 1);
    dat_last   = org_q ? 5'd15 : 5'd7;
    rd_waddr_o = org_q ? rd_adr[WAW-1:0] : rd_adr[BAW-1:1];
    rd_val     = org_q ? rd_word_i
                       : {8'h00, (rd_adr[0] ? rd_word_i[15:8] : rd_word_i[7:0])};
    rd_idx     = dat_last[3:0] - rd_cnt;
    rd_bit     = rd_val[rd_idx];
    rd_inc     = (rd_adr + 1'b1) & amask;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= S_IDLE;  pend <= OP_NONE;
      cs_d <= 1'b0;     sck_d <= 1'b0;   org_q <= 1'b1;  q_r <= 1'b0;
      opc <= '0;        adr <= '0;       rd_adr <= '0;   dat <= '0;
      cnt <= '0;        rd_cnt <= '0;
      cmd_valid_o <= 1'b0; cmd_op_o <= OP_NONE; cmd_wide_o <= 1'b0;
      cmd_addr_o  <= '0;   cmd_data_o <= '0;
    end else begin
      cs_d        <= cs_s_i;
      sck_d       <= sck_s_i;
      cmd_valid_o <= 1'b0;
      if (!cs_s_i) begin
        if (state == S_FIN) begin
          cmd_valid_o <= 1'b1;
          cmd_op_o    <= pend;
          cmd_wide_o  <= org_q;
          cmd_addr_o  <= adr;
          cmd_data_o  <= dat;
        end
        state <= S_IDLE;
        q_r   <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE: if (cs_rise && !sck_s_i) state <= S_ARM;
          S_ARM: if (sck_rise && din_s_i) begin
            state <= S_OPC;
            cnt   <= '0;
            org_q <= org_i;
            adr   <= '0;
            dat   <= '0;
          end
          S_OPC: if (sck_rise) begin
            opc <= {opc[0], din_s_i};
            if (cnt == 5'd1) begin
              state <= S_ADR;
              cnt   <= '0;
            end else cnt <= cnt + 5'd1;
          end
          S_ADR: if (sck_rise) begin
            adr <= adr_nxt;
            if (cnt == adr_last) begin
              cnt <= '0;
              adr <= adr_nxt & amask;
              unique case (opc)
                2'b10: begin
                  state  <= S_RD;
                  rd_adr <= adr_nxt & amask;
                  rd_cnt <= '0;
                  q_r    <= 1'b0;
                end
                2'b01: begin pend <= OP_WRITE; state <= S_DAT; end
                2'b11: begin pend <= OP_ERASE; state <= S_FIN; end
                default: begin
                  unique case (ext)
                    2'b11:   begin pend <= OP_EWEN; state <= S_FIN; end
                    2'b00:   begin pend <= OP_EWDS; state <= S_FIN; end
                    2'b10:   begin pend <= OP_ERAL; state <= S_FIN; end
                    default: begin pend <= OP_WRAL; state <= S_DAT; end
                  endcase
                end
              endcase
            end else cnt <= cnt + 5'd1;
          end
          S_DAT: if (sck_rise) begin
            dat <= {dat[14:0], din_s_i};
            if (cnt == dat_last) state <= S_FIN;
            else cnt <= cnt + 5'd1;
          end
          S_RD: if (sck_rise) begin
            q_r <= rd_bit;
            if (rd_cnt == dat_last[3:0]) begin
              rd_cnt <= '0;
              rd_adr <= rd_inc;
            end else rd_cnt <= rd_cnt + 4'd1;
          end
          S_FIN: if (sck_rise) state <= S_BAD;
          default: ;
        endcase
      end
    end
  end

  assign q_oe_o = (state == S_RD);
  assign q_o    = q_r;
endmodule

// File: rtl/uw_front.sv
module uw_front import uw_pkg::*; #(
  parameter int MEM_WORDS = 64,
  localparam int WAW = $clog2(MEM_WORDS),
  localparam int BAW = WAW + 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_i,
  input  logic           sck_i,
  input  logic           din_i,
  input  logic           org_i,
  output logic           q_o,
  output logic           q_oe_o,
  output logic           cmd_valid_o,
  output logic [2:0]     cmd_op_o,
  output logic           cmd_wide_o,
  output logic [BAW-1:0] cmd_addr_o,
  output logic [15:0]    cmd_data_o
);
  logic [2:0]     sync_q;
  logic           cs_s, sck_s, din_s;
  logic [WAW-1:0] rd_waddr;
  logic [15:0]    rd_word;
  uw_op_e         op;

  uw_sync #(.W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_i, sck_i, din_i}),
    .q_o   (sync_q)
  );
  assign {cs_s, sck_s, din_s} = sync_q;

  uw_decoder #(.MEM_WORDS(MEM_WORDS)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_s_i     (cs_s),
    .sck_s_i    (sck_s),
    .din_s_i    (din_s),
    .org_i      (org_i),
    .rd_word_i  (rd_word),
    .rd_waddr_o (rd_waddr),
    .q_o        (q_o),
    .q_oe_o     (q_oe_o),
    .cmd_valid_o(cmd_valid_o),
    .cmd_op_o   (op),
    .cmd_wide_o (cmd_wide_o),
    .cmd_addr_o (cmd_addr_o),
    .cmd_data_o (cmd_data_o)
  );
  assign cmd_op_o = op;

  uw_array #(.MEM_WORDS(MEM_WORDS)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cmd_valid_o),
    .op_i      (op),
    .wide_i    (cmd_wide_o),
    .addr_i    (cmd_addr_o),
    .data_i    (cmd_data_o),
    .rd_waddr_i(rd_waddr),
    .rd_word_o (rd_word)
  );
endmodule

// File: rtl/uw_chk.sv
module uw_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_s,
  input logic       q_o,
  input logic       q_oe_o,
  input logic       cmd_valid_o,
  input logic [2:0] cmd_op_o
);
  a_r1_q_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q_oe_o |-> !q_o);
  a_r4_oe_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |=> !q_oe_o);
  a_r4_dummy_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_oe_o) |-> !q_o);
  a_r3_op_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (cmd_op_o >= 3'd1 && cmd_op_o <= 3'd6));
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |=> !cmd_valid_o);
  a_r7_after_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(!cs_s));
endmodule

bind uw_front uw_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_s       (cs_s),
  .q_o        (q_o),
  .q_oe_o     (q_oe_o),
  .cmd_valid_o(cmd_valid_o),
  .cmd_op_o   (cmd_op_o)
);

// File: tb/sim_uw_front.sv
module sim_uw_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, din = 1'b0, org = 1'b1;
  logic q, q_oe, cmd_valid, cmd_wide;
  logic [2:0] cmd_op;
  logic [6:0] cmd_addr;
  logic [15:0] cmd_data;

  int checks = 0, errors = 0, nstb = 0;
  logic [2:0] l_op;
  logic l_wide;
  logic [6:0] l_addr;
  logic [15:0] l_data;
  logic qs;
  bit done = 0;

  always #4 clk = ~clk;

  uw_front u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sck_i(sck), .din_i(din), .org_i(org),
    .q_o(q), .q_oe_o(q_oe), .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op),
    .cmd_wide_o(cmd_wide), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data)
  );

  always @(negedge clk) if (cmd_valid) begin
    nstb++; l_op = cmd_op; l_wide = cmd_wide; l_addr = cmd_addr; l_data = cmd_data;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bitc(input logic b);
    din = b;
    repeat (8) @(negedge clk);
    sck = 1'b1;
    repeat (8) @(negedge clk);
    sck = 1'b0;
    qs = q;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) bitc(v[i]);
  endtask

  task automatic sel_on();
    sck = 1'b0; cs = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic sel_off();
    cs = 1'b0; din = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  function automatic int aw(input logic w); return w ? 6 : 7; endfunction
  function automatic int dw(input logic w); return w ? 16 : 8; endfunction

  task automatic do_write(input logic w, input logic [6:0] a, input logic [15:0] d);
    org = w; sel_on(); send(3'b101, 3); send(a, aw(w)); send(d, dw(w)); sel_off();
  endtask

  task automatic rd_begin(input logic w, input logic [6:0] a);
    org = w; sel_on(); send(3'b110, 3); send(a, aw(w));
    chk("R4 dummy bit", qs, 0);
    chk("R4 oe during read", q_oe, 1);
  endtask

  task automatic rd_word(input logic w, output logic [15:0] r);
    r = '0;
    for (int i = 0; i < dw(w); i++) begin bitc(1'b0); r = {r[14:0], qs}; end
  endtask

  task automatic rd_one(input string tag, input logic w, input logic [6:0] a, input logic [15:0] e);
    logic [15:0] r;
    rd_begin(w, a); rd_word(w, r); sel_off();
    chk(tag, r, e);
  endtask

  // {wide, waddr, wdata, rwide, raddr, expected}
  localparam logic [47:0] VEC [6] = '{
    {1'b1, 7'h05, 16'hA55A, 1'b1, 7'h05, 16'hA55A},
    {1'b0, 7'h0B, 16'h003C, 1'b1, 7'h05, 16'h3C5A},
    {1'b0, 7'h0A, 16'h0081, 1'b0, 7'h0A, 16'h0081},
    {1'b1, 7'h00, 16'h1234, 1'b0, 7'h00, 16'h0034},
    {1'b1, 7'h3F, 16'hBEEF, 1'b0, 7'h7F, 16'h00BE},
    {1'b0, 7'h01, 16'h00C3, 1'b1, 7'h00, 16'hC334}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    int n0;
    repeat (5) @(negedge clk);
    chk("R1 oe after reset", q_oe, 0);
    chk("R1 q after reset", q, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    rd_one("R1 erased word", 1'b1, 7'h03, 16'hFFFF);
    rd_one("R1 erased byte", 1'b0, 7'h11, 16'h00FF);
    chk("R1 no strobe", nstb, 0);
    chk("R4 oe low after deselect", q_oe, 0);

    foreach (VEC[k]) begin
      n0 = nstb;
      do_write(VEC[k][47], VEC[k][46:40], VEC[k][39:24]);
      chk("R7 strobe count", nstb, n0 + 1);
      chk("R3 write op code", l_op, 3'd1);
      chk("R7 strobe addr", l_addr, VEC[k][46:40]);
      chk("R7 strobe data", l_data, VEC[k][39:24]);
      rd_one("R6 read back", VEC[k][23], VEC[k][22:16], VEC[k][15:0]);
    end

    // R5: stream with wrap, words then bytes
    rd_begin(1'b1, 7'h3F);
    rd_word(1'b1, r); chk("R5 word top", r, 16'hBEEF);
    rd_word(1'b1, r); chk("R5 word wrap", r, 16'hC334);
    rd_word(1'b1, r); chk("R5 word next", r, 16'hFFFF);
    sel_off();
    rd_begin(1'b0, 7'h7F);
    rd_word(1'b0, r); chk("R5 byte top", r, 16'h00BE);
    rd_word(1'b0, r); chk("R5 byte wrap", r, 16'h0034);
    rd_word(1'b0, r); chk("R5 byte next", r, 16'h00C3);
    sel_off();

    // R9: extra clock after final data bit
    n0 = nstb; org = 1'b1;
    sel_on(); send(3'b101, 3); send(7'h02, 6); send(16'h5555, 16); bitc(1'b0); sel_off();
    chk("R9 no strobe on extra clock", nstb, n0);
    rd_one("R9 array unchanged", 1'b1, 7'h02, 16'hFFFF);

    // R10: deselect mid data
    n0 = nstb;
    sel_on(); send(3'b101, 3); send(7'h02, 6); send(8'hAA, 8); sel_off();
    chk("R10 no strobe on short cmd", nstb, n0);
    rd_one("R10 array unchanged", 1'b1, 7'h02, 16'hFFFF);

    // R2: select while clock high is ignored
    n0 = nstb;
    sck = 1'b1; repeat (4) @(negedge clk); cs = 1'b1; repeat (8) @(negedge clk);
    sck = 1'b0; repeat (8) @(negedge clk);
    send(3'b101, 3); send(7'h02, 6); send(16'h7777, 16); sel_off();
    chk("R2 no decode after select with clock high", nstb, n0);
    rd_one("R2 array unchanged", 1'b1, 7'h02, 16'hFFFF);
    // R2: leading zeros before start bit
    sel_on(); send(3'b000, 3); send(3'b101, 3); send(7'h02, 6); send(16'h0F0F, 16); sel_off();
    chk("R2 leading zeros strobe", nstb, n0 + 1);
    rd_one("R2 write after leading zeros", 1'b1, 7'h02, 16'h0F0F);

    // R11: enable / disable
    org = 1'b1; sel_on(); send(3'b100, 3); send(6'b110000, 6); sel_off();
    chk("R11 enable code", l_op, 3'd3);
    org = 1'b0; sel_on(); send(3'b100, 3); send(7'b0010101, 7); sel_off();
    chk("R11 disable code", l_op, 3'd4);
    chk("R11 disable byte mode", l_wide, 0);
    rd_one("R11 array unchanged", 1'b1, 7'h02, 16'h0F0F);

    // R8: erase one byte, erase all, write all
    org = 1'b0; sel_on(); send(3'b111, 3); send(7'h0A, 7); sel_off();
    chk("R3 erase code", l_op, 3'd2);
    rd_one("R8 byte erase", 1'b1, 7'h05, 16'h3CFF);
    org = 1'b1; sel_on(); send(3'b100, 3); send(6'b100000, 6); sel_off();
    chk("R8 erase-all code", l_op, 3'd5);
    rd_one("R8 erase-all", 1'b1, 7'h00, 16'hFFFF);
    org = 1'b0; sel_on(); send(3'b100, 3); send(7'b0100000, 7); send(8'h5A, 8); sel_off();
    chk("R8 write-all code", l_op, 3'd6);
    rd_one("R8 write-all byte fill", 1'b1, 7'h09, 16'h5A5A);
    org = 1'b1; sel_on(); send(3'b100, 3); send(6'b010000, 6); send(16'h6789, 16); sel_off();
    rd_one("R8 write-all word", 1'b1, 7'h20, 16'h6789);
    rd_one("R8 write-all high byte", 1'b0, 7'h41, 16'h0067);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule